// File: doc/BRIEF.md
# Transmit Buffer Status and Abort Control

This block keeps the per-buffer status of the three transmit message buffers of a CAN-style controller. A CPU reaches it over a small byte bus. Writing a one to a buffer's empty flag hands that buffer to the transmit engine. Each buffer also has an interrupt enable, an abort request bit and an abort acknowledge bit. The engine reports two kinds of event on side inputs: a buffer's message went out, or a buffer's abort completed. Either event makes the buffer empty again.

The block drives three outputs. The first is a per-buffer "scheduled" signal to the transmit engine. The second is a level-sensitive transmit interrupt. The third is a per-buffer lock that blocks CPU access to a buffer's storage while it waits to be sent. Initialization mode and listen mode both restrict what the CPU can change.

Top module: `txbuf_ctrl`

## Requirements
- R1: After reset, all empty flags read 1 and the enables, abort requests and abort acknowledges read 0. `tx_pending`, `buf_lock`, `tx_irq` and `bus_rdata` are all 0.
- R2: The empty flags sit in bits 2:0 (bit n is buffer n) at address 0. Bits 7:3 read 0. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R3: A pulse on `eng_sent[n]` or `eng_abort_done[n]` sets empty flag n at the next clock edge. If a CPU clear of flag n arrives in the same cycle, the set wins.
- R4: Setting empty flag n clears abort request n. A pulse on `eng_abort_done[n]` sets abort acknowledge n. A CPU clear of empty flag n also clears abort acknowledge n.
- R5: The abort requests sit in bits 2:0 at address 2. Writing 1 sets request n only if empty flag n is 0. Writing 1 for an empty buffer has no effect, and neither does writing 0. The abort acknowledges are read-only, in bits 2:0 at address 3.
- R6: While `init_req` and `init_ack` are both 1, the empty flags are held at 1, the abort bits are held at 0, and writes to address 0 are ignored. Writes to address 0 take effect only when both inputs are 0.
- R7: While `listen_mode` is 1, writes to address 0 clear no flag. `tx_pending` is all 0 after any edge at which `listen_mode` was 1.
- R8: `buf_lock[n]` is the inverse of empty flag n. `tx_pending[n]` is set after an edge only when the new empty flag n is 0 and `listen_mode` was 0.
- R9: The interrupt enables sit in bits 2:0 at address 1. `tx_irq` is a registered level: the OR over n of (empty flag n AND enable n), using the values after the same edge.
- R10: A read request (`bus_sel`=1, `bus_we`=0) returns the addressed register on `bus_rdata` after the next edge. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| listen_mode | input | 1 | Listen-only mode active |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| eng_sent | input | 3 | Per-buffer pulse: message sent |
| eng_abort_done | input | 3 | Per-buffer pulse: abort completed |
| tx_pending | output | 3 | Per-buffer scheduled-for-transmission |
| abort_pending | output | 3 | Per-buffer abort request |
| tx_irq | output | 1 | Transmit interrupt level |
| buf_lock | output | 3 | Per-buffer storage access block |

## Verification
The in-RTL assertions check several rules on every cycle. An abort request never sits on an empty buffer. A rising empty flag always leaves its abort request clear, and a falling one leaves its acknowledge clear. An engine event always leaves the flag set. Initialization holds every flag, listen mode keeps `tx_pending` at zero, a scheduled buffer is always locked, and the interrupt never fires without an enable. Only the bench's scenarios can show the following: the register addresses and bit positions, write-one-to-clear with its ignored zeros, the set-beats-clear race, writes refused while only one initialization input is high, and the exact read-back values.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DATA_W    = 8;
  localparam logic [ADDR_W-1:0] A_EMPTY = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ABREQ = 3'd2;
  localparam logic [ADDR_W-1:0] A_ABACK = 3'd3;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/txb_slot.sv
module txb_slot (
  input  logic clk,
  input  logic rst,
  input  logic init_hold,
  input  logic cpu_clr,
  input  logic abreq_wr,
  input  logic ien_we,
  input  logic ien_val,
  input  logic hw_sent,
  input  logic hw_abort_done,
  output logic empty_q,
  output logic empty_n,
  output logic ien_q,
  output logic ien_n,
  output logic abreq_q,
  output logic aback_q
);
  logic hw_set;
  logic abreq_n;
  logic aback_n;

  assign hw_set = hw_sent | hw_abort_done;

  always_comb begin
    empty_n = empty_q;
    abreq_n = abreq_q;
    aback_n = aback_q;
    ien_n   = ien_we ? ien_val : ien_q;
    if (init_hold) begin
      empty_n = 1'b1;
      abreq_n = 1'b0;
      aback_n = 1'b0;
    end else begin
      if (hw_set) begin
        empty_n = 1'b1;
        abreq_n = 1'b0;
      end else begin
        if (cpu_clr) begin
          empty_n = 1'b0;
          aback_n = 1'b0;
        end
        if (abreq_wr && !empty_q) abreq_n = 1'b1;
      end
      if (hw_abort_done) aback_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      ien_q   <= 1'b0;
      abreq_q <= 1'b0;
      aback_q <= 1'b0;
    end else begin
      empty_q <= empty_n;
      ien_q   <= ien_n;
      abreq_q <= abreq_n;
      aback_q <= aback_n;
    end
  end

  a_r5_req_only_when_full: assert property (@(posedge clk) disable iff (rst)
    abreq_q |-> !empty_q);
  a_r4_set_drops_request: assert property (@(posedge clk) disable iff (rst)
    $rose(empty_q) |-> !abreq_q);
  a_r4_clear_drops_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_q) |-> !aback_q);
  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (hw_sent || hw_abort_done) |=> empty_q);
  a_r6_init_holds_flag: assert property (@(posedge clk) disable iff (rst)
    init_hold |=> (empty_q && !abreq_q && !aback_q));
endmodule

// File: rtl/txb_bus.sv
module txb_bus
  import txb_pkg::*;
#(
  parameter int unsigned NBUF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag_writable,
  input  logic              listen_mode,
  input  logic [NBUF-1:0]   empty_vec,
  input  logic [NBUF-1:0]   ien_vec,
  input  logic [NBUF-1:0]   abreq_vec,
  input  logic [NBUF-1:0]   aback_vec,
  output logic [NBUF-1:0]   clr_vec,
  output logic [NBUF-1:0]   abreq_wr_vec,
  output logic              ien_we,
  output logic [NBUF-1:0]   ien_wval,
  output logic [DATA_W-1:0] rdata_q
);
  bus_op_e          op;
  logic [NBUF-1:0]  wbits;
  logic [NBUF-1:0]  sel_vec;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (!bus_sel)    op = BUS_IDLE;
    else if (bus_we) op = BUS_WRITE;
    else             op = BUS_READ;
  end

  assign wbits        = bus_wdata[NBUF-1:0];
  assign clr_vec      = (op == BUS_WRITE && bus_addr == A_EMPTY && flag_writable && !listen_mode)
                        ? wbits : '0;
  assign abreq_wr_vec = (op == BUS_WRITE && bus_addr == A_ABREQ) ? wbits : '0;
  assign ien_we       = (op == BUS_WRITE && bus_addr == A_IEN);
  assign ien_wval     = wbits;

  always_comb begin
    case (bus_addr)
      A_EMPTY: sel_vec = empty_vec;
      A_IEN:   sel_vec = ien_vec;
      A_ABREQ: sel_vec = abreq_vec;
      A_ABACK: sel_vec = aback_vec;
      default: sel_vec = '0;
    endcase
    rd_mux = '0;
    rd_mux[NBUF-1:0] = sel_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (op == BUS_READ) rdata_q <= rd_mux;
  end

  a_r7_listen_blocks_clear: assert property (@(posedge clk) disable iff (rst)
    listen_mode |-> (clr_vec == '0));
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txb_pkg::*;
#(
  parameter int unsigned NBUF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              listen_mode,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NBUF-1:0]   eng_sent,
  input  logic [NBUF-1:0]   eng_abort_done,
  output logic [NBUF-1:0]   tx_pending,
  output logic [NBUF-1:0]   abort_pending,
  output logic              tx_irq,
  output logic [NBUF-1:0]   buf_lock
);
  logic            init_hold;
  logic            flag_writable;
  logic [NBUF-1:0] empty_q, empty_n, ien_q, ien_n, abreq_q, aback_q;
  logic [NBUF-1:0] clr_vec, abreq_wr_vec, ien_wval;
  logic            ien_we;
  logic [NBUF-1:0] pend_q;
  logic            irq_q;

  assign init_hold     = init_req & init_ack;
  assign flag_writable = ~init_req & ~init_ack;

  txb_bus #(.NBUF(NBUF)) u_bus (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .flag_writable(flag_writable), .listen_mode(listen_mode),
    .empty_vec(empty_q), .ien_vec(ien_q), .abreq_vec(abreq_q), .aback_vec(aback_q),
    .clr_vec(clr_vec), .abreq_wr_vec(abreq_wr_vec), .ien_we(ien_we), .ien_wval(ien_wval),
    .rdata_q(bus_rdata)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    txb_slot u_slot (
      .clk(clk), .rst(rst), .init_hold(init_hold),
      .cpu_clr(clr_vec[g]), .abreq_wr(abreq_wr_vec[g]),
      .ien_we(ien_we), .ien_val(ien_wval[g]),
      .hw_sent(eng_sent[g]), .hw_abort_done(eng_abort_done[g]),
      .empty_q(empty_q[g]), .empty_n(empty_n[g]),
      .ien_q(ien_q[g]), .ien_n(ien_n[g]),
      .abreq_q(abreq_q[g]), .aback_q(aback_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= ~empty_n & {NBUF{~listen_mode}};
      irq_q  <= |(empty_n & ien_n);
    end
  end

  assign tx_pending    = pend_q;
  assign tx_irq        = irq_q;
  assign buf_lock      = ~empty_q;
  assign abort_pending = abreq_q;

  a_r8_pending_is_locked: assert property (@(posedge clk) disable iff (rst)
    |(tx_pending & ~buf_lock) == 1'b0);
  a_r7_listen_no_pending: assert property (@(posedge clk) disable iff (rst)
    listen_mode |=> (tx_pending == '0));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (ien_q != '0));
endmodule

// File: tb/txbuf_ctrl_bench.sv
module txbuf_ctrl_bench;
  typedef struct packed {
    logic [1:0] op;     // 0 idle, 1 read, 2 write
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [2:0] sent;
    logic [2:0] abd;
    logic       lis;
    logic [2:0] e_pend;
    logic [2:0] e_lock;
    logic       e_irq;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'd1, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000, 1'b0, 8'h07}, // R2 R10 reset read
    '{2'd2, 3'd1, 8'h07, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000, 1'b1, 8'h00}, // R9
    '{2'd2, 3'd0, 8'h05, 3'b000, 3'b000, 1'b0, 3'b101, 3'b101, 1'b1, 8'h00}, // R2 R8
    '{2'd2, 3'd1, 8'h05, 3'b000, 3'b000, 1'b0, 3'b101, 3'b101, 1'b0, 8'h00}, // R9
    '{2'd1, 3'd1, 8'h00, 3'b000, 3'b000, 1'b0, 3'b101, 3'b101, 1'b0, 8'h05}, // R9 readback
    '{2'd2, 3'd2, 8'h07, 3'b000, 3'b000, 1'b0, 3'b101, 3'b101, 1'b0, 8'h00}, // R5
    '{2'd1, 3'd2, 8'h00, 3'b000, 3'b000, 1'b0, 3'b101, 3'b101, 1'b0, 8'h05}, // R5 empty buf ignored
    '{2'd0, 3'd0, 8'h00, 3'b000, 3'b001, 1'b0, 3'b100, 3'b100, 1'b1, 8'h00}, // R3 R4 abort done
    '{2'd1, 3'd3, 8'h00, 3'b000, 3'b000, 1'b0, 3'b100, 3'b100, 1'b1, 8'h01}, // R4 ack set
    '{2'd1, 3'd2, 8'h00, 3'b000, 3'b000, 1'b0, 3'b100, 3'b100, 1'b1, 8'h04}, // R4 req cleared
    '{2'd0, 3'd0, 8'h00, 3'b100, 3'b000, 1'b0, 3'b000, 3'b000, 1'b1, 8'h00}, // R3 sent
    '{2'd2, 3'd0, 8'h01, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}, // R2
    '{2'd1, 3'd3, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}, // R4 ack cleared
    '{2'd2, 3'd0, 8'h06, 3'b000, 3'b000, 1'b1, 3'b000, 3'b001, 1'b1, 8'h00}, // R7
    '{2'd0, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}, // R8
    '{2'd2, 3'd0, 8'h04, 3'b100, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}, // R3 race
    '{2'd1, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h06}, // R3 R7 readback
    '{2'd2, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}, // R2 zero write
    '{2'd1, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h06}, // R2 readback
    '{2'd1, 3'd5, 8'h00, 3'b000, 3'b000, 1'b0, 3'b001, 3'b001, 1'b1, 8'h00}  // R10 unmapped
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_req = 1'b0, init_ack = 1'b0, listen_mode = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] eng_sent = '0, eng_abort_done = '0;
  logic [2:0] tx_pending, abort_pending, buf_lock;
  logic       tx_irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  txbuf_ctrl u_txbuf_ctrl (
    .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
    .listen_mode(listen_mode), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_sent(eng_sent), .eng_abort_done(eng_abort_done),
    .tx_pending(tx_pending), .abort_pending(abort_pending),
    .tx_irq(tx_irq), .buf_lock(buf_lock)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [2:0] a, logic [7:0] d,
                       logic [2:0] s, logic [2:0] ab, logic lis);
    bus_sel = (op != 2'd0); bus_we = (op == 2'd2);
    bus_addr = a; bus_wdata = d; eng_sent = s; eng_abort_done = ab;
    listen_mode = lis;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; eng_sent = '0; eng_abort_done = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pend", {5'd0, tx_pending}, 8'h00);
    check("R1 lock", {5'd0, buf_lock}, 8'h00);
    check("R1 irq", {7'd0, tx_irq}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 abort", {5'd0, abort_pending}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].sent, VECS[i].abd, VECS[i].lis);
      check("R8 vec pend", {5'd0, tx_pending}, {5'd0, VECS[i].e_pend});
      check("R8 vec lock", {5'd0, buf_lock}, {5'd0, VECS[i].e_lock});
      check("R9 vec irq", {7'd0, tx_irq}, {7'd0, VECS[i].e_irq});
      if (VECS[i].op == 2'd1) check("R10 vec rdata", bus_rdata, VECS[i].e_rd);
    end

    // State now: empty=110, ien=101, abreq=000, ack=000
    apply(2'd2, 3'd2, 8'h01, 3'b000, 3'b000, 1'b0);
    check("R5 abort_pending", {5'd0, abort_pending}, 8'h01);
    // R6: only one init input high, write to flags refused
    init_req = 1'b1;
    apply(2'd2, 3'd0, 8'h02, 3'b000, 3'b000, 1'b0);
    check("R6 partial init lock", {5'd0, buf_lock}, 8'h01);
    init_ack = 1'b1;
    apply(2'd0, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0);
    check("R6 init hold lock", {5'd0, buf_lock}, 8'h00);
    check("R6 init hold pend", {5'd0, tx_pending}, 8'h00);
    check("R6 init abort clr", {5'd0, abort_pending}, 8'h00);
    apply(2'd2, 3'd0, 8'h07, 3'b000, 3'b000, 1'b0);
    check("R6 init write ignored", {5'd0, buf_lock}, 8'h00);
    init_req = 1'b0; init_ack = 1'b0;
    apply(2'd2, 3'd0, 8'h02, 3'b000, 3'b000, 1'b0);
    check("R6 writable after", {5'd0, tx_pending}, 8'h02);
    apply(2'd1, 3'd0, 8'h00, 3'b000, 3'b000, 1'b0);
    check("R2 flags read", bus_rdata, 8'h05);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule